// File: doc/BRIEF.md
# Trap Return Privilege Unit

This block carries out the two trap-return operations of a processor core that may include a hypervisor extension: the return from machine level and the return from supervisor level. A caller presents one return request together with a snapshot of the current privilege, the virtualization flag, the relevant status and hypervisor-status bits, both saved exception PCs and the extension enables. One clock later the block answers in one of two ways. On a legal return it pulses a redirect strobe with the target PC and registers a new status image, privilege and virtualization flag. On an illegal return it pulses an exception strobe with a cause code and leaves the registered state as it was.

The request side uses a valid/ready handshake. Ready is low during reset and high in every cycle after it, so the block never stalls a request. A request is taken on any clock edge where both are high. The result strobes have no ready and last exactly one cycle. Requests may arrive in back-to-back cycles. Register-bank swapping is not done here: the block only raises a one-cycle swap request beside the redirect.

Privilege is encoded as user = 0, supervisor = 1, machine = 3. The single supervisor previous-privilege bit uses 0 for user and 1 for supervisor.

Top module: `trap_return_unit`

## Requirements
- R1: A machine return (`req_sret` = 0) with `cur_priv` other than 3 raises an exception with cause 2 (illegal instruction).
- R2: A supervisor return (`req_sret` = 1) with `cur_priv` = 0 raises an exception with cause 2.
- R3: When `ext_c` = 0 and bits [1:0] of the selected return PC are not both zero, the request raises an exception with cause 0 (misaligned address). When `ext_c` = 1, a PC with bit 1 set is accepted unchanged. The selected PC is `mepc` for a machine return and `sepc` for a supervisor return.
- R4: A supervisor return with `st_tsr` = 1 raises cause 2 when `cur_priv` is below 3. At `cur_priv` = 3 it is accepted.
- R5: A supervisor return with `ext_h` = 1, `cur_virt` = 1 and `hs_vtsr` = 1 raises cause 22 (virtual instruction).
- R6: A legal machine return sets `o_mie` to the old MPIE, sets `o_mpie` to 1, `o_mpp` to 0 and `o_mpv` to 0, and sets `o_priv` to the old `st_mpp`. The supervisor fields pass through unchanged.
- R7: On a legal machine return with `ext_h` = 1, `o_virt` takes the old `st_mpv` and `swap_req` pulses when that value is 1. With `ext_h` = 0, `o_virt` keeps `cur_virt` and `swap_req` stays low.
- R8: A legal supervisor return with `ext_h` = 1 and `cur_virt` = 0 sets `o_priv` from `st_spp`, sets `o_virt` and `swap_req` from `hs_spv`, clears `o_spv` and `o_spp`, copies SPIE into `o_sie` and sets `o_spie` to 1.
- R9: Any other legal supervisor return copies SPIE into `o_sie`, sets `o_spie` to 1, clears `o_spp`, sets `o_priv` from `st_spp`, and keeps `cur_virt` and `hs_spv`. The machine fields pass through unchanged.
- R10: A machine return with `pmp_on` = 1, `pmp_empty` = 1 and `st_mpp` other than 3 raises cause 2.
- R11: When more than one check fails, the first check in this order sets the cause. For a machine return the order is the privilege check, then the alignment check, then the protection check. For a supervisor return it is the privilege check, then the alignment check, then the trap-return bit, then the virtual trap bit.
- R12: The result appears in the cycle after acceptance. On that cycle exactly one of `redir_valid` and `exc_valid` is high, for one cycle only. No registered output field, privilege or virtualization value changes on an exception cycle.
- R13: During reset and after it, `o_priv` reads 3 and every other state output and strobe reads 0. `req_ready` is 1 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Return request present |
| req_ready | output | 1 | Request can be taken (high after reset) |
| req_sret | input | 1 | 1 = supervisor return, 0 = machine return |
| cur_priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| cur_virt | input | 1 | Current virtualization flag |
| ext_c | input | 1 | Compressed extension enabled |
| ext_h | input | 1 | Hypervisor extension present |
| pmp_on | input | 1 | Memory protection unit present |
| pmp_empty | input | 1 | No protection regions configured |
| st_mie | input | 1 | Machine interrupt enable |
| st_mpie | input | 1 | Machine previous interrupt enable |
| st_mpp | input | 2 | Machine previous privilege |
| st_mpv | input | 1 | Machine previous virtualization |
| st_sie | input | 1 | Supervisor interrupt enable |
| st_spie | input | 1 | Supervisor previous interrupt enable |
| st_spp | input | 1 | Supervisor previous privilege |
| st_tsr | input | 1 | Trap supervisor returns |
| hs_spv | input | 1 | Hypervisor-status previous virtualization |
| hs_vtsr | input | 1 | Trap supervisor returns in virtual mode |
| mepc | input | XLEN | Machine exception PC |
| sepc | input | XLEN | Supervisor exception PC |
| redir_valid | output | 1 | One-cycle redirect strobe |
| redir_pc | output | XLEN | Return target PC |
| swap_req | output | 1 | Register-bank swap request, with redirect |
| exc_valid | output | 1 | One-cycle exception strobe |
| exc_cause | output | 5 | Exception cause (0, 2 or 22) |
| o_priv | output | 2 | New privilege |
| o_virt | output | 1 | New virtualization flag |
| o_mie | output | 1 | New MIE |
| o_mpie | output | 1 | New MPIE |
| o_mpp | output | 2 | New MPP |
| o_mpv | output | 1 | New MPV |
| o_sie | output | 1 | New SIE |
| o_spie | output | 1 | New SPIE |
| o_spp | output | 1 | New SPP |
| o_spv | output | 1 | New SPV |

## Verification
The in-line properties check every cycle that the two result strobes never coincide and that an exception leaves all registered state untouched. They also check that every redirect after a machine return came from machine privilege with the machine fields cleared as required, that every supervisor redirect leaves SPIE set and SPP cleared, and that the misaligned and virtual-instruction causes appear only under their enabling conditions. The check order when several conditions fail at once, the exact values restored into privilege and virtualization, the swap request, and the protection-region rule are shown only by the bench. It runs directed corner cases and seeded random requests against its own model.

// File: rtl/trp_pkg.sv
package trp_pkg;
  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam int CAUSE_W = 5;
  localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN = 5'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL  = 5'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_VIRT     = 5'd22;

  typedef struct packed {
    logic       mie;
    logic       mpie;
    logic [1:0] mpp;
    logic       mpv;
    logic       sie;
    logic       spie;
    logic       spp;
    logic       spv;
  } stat_t;
endpackage

// File: rtl/trp_legality.sv
module trp_legality
  import trp_pkg::*;
(
  input  logic               is_sret,
  input  logic [1:0]         priv,
  input  logic               virt,
  input  logic               ext_c,
  input  logic               ext_h,
  input  logic               pmp_on,
  input  logic               pmp_empty,
  input  logic               tsr,
  input  logic               vtsr,
  input  logic [1:0]         mpp,
  input  logic [1:0]         pc_low,
  output logic               fault,
  output logic [CAUSE_W-1:0] cause
);
  logic misaligned;
  assign misaligned = !ext_c && (pc_low != 2'b00);

  // First failing check decides the cause
  always_comb begin
    fault = 1'b0;
    cause = CAUSE_MISALIGN;
    if (!is_sret) begin
      if (priv != PRIV_M) begin
        fault = 1'b1; cause = CAUSE_ILLEGAL;
      end else if (misaligned) begin
        fault = 1'b1; cause = CAUSE_MISALIGN;
      end else if (pmp_on && pmp_empty && (mpp != PRIV_M)) begin
        fault = 1'b1; cause = CAUSE_ILLEGAL;
      end
    end else begin
      if (priv < PRIV_S) begin
        fault = 1'b1; cause = CAUSE_ILLEGAL;
      end else if (misaligned) begin
        fault = 1'b1; cause = CAUSE_MISALIGN;
      end else if (tsr && (priv < PRIV_M)) begin
        fault = 1'b1; cause = CAUSE_ILLEGAL;
      end else if (ext_h && virt && vtsr) begin
        fault = 1'b1; cause = CAUSE_VIRT;
      end
    end
  end
endmodule

// File: rtl/trp_fields.sv
module trp_fields
  import trp_pkg::*;
(
  input  logic       is_sret,
  input  logic       ext_h,
  input  logic       virt,
  input  stat_t      st_in,
  output stat_t      st_out,
  output logic [1:0] new_priv,
  output logic       new_virt,
  output logic       swap
);
  always_comb begin
    st_out   = st_in;
    new_virt = virt;
    swap     = 1'b0;
    if (!is_sret) begin
      st_out.mie  = st_in.mpie;
      st_out.mpie = 1'b1;
      st_out.mpp  = PRIV_U;
      st_out.mpv  = 1'b0;
      new_priv    = st_in.mpp;
      if (ext_h) begin
        new_virt = st_in.mpv;
        swap     = st_in.mpv;
      end
    end else begin
      st_out.sie  = st_in.spie;
      st_out.spie = 1'b1;
      st_out.spp  = 1'b0;
      new_priv    = st_in.spp ? PRIV_S : PRIV_U;
      if (ext_h && !virt) begin
        st_out.spv = 1'b0;
        new_virt   = st_in.spv;
        swap       = st_in.spv;
      end
    end
  end
endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
  import trp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_sret,
  input  logic [1:0]         cur_priv,
  input  logic               cur_virt,
  input  logic               ext_c,
  input  logic               ext_h,
  input  logic               pmp_on,
  input  logic               pmp_empty,
  input  logic               st_mie,
  input  logic               st_mpie,
  input  logic [1:0]         st_mpp,
  input  logic               st_mpv,
  input  logic               st_sie,
  input  logic               st_spie,
  input  logic               st_spp,
  input  logic               st_tsr,
  input  logic               hs_spv,
  input  logic               hs_vtsr,
  input  logic [XLEN-1:0]    mepc,
  input  logic [XLEN-1:0]    sepc,
  output logic               redir_valid,
  output logic [XLEN-1:0]    redir_pc,
  output logic               swap_req,
  output logic               exc_valid,
  output logic [CAUSE_W-1:0] exc_cause,
  output logic [1:0]         o_priv,
  output logic               o_virt,
  output logic               o_mie,
  output logic               o_mpie,
  output logic [1:0]         o_mpp,
  output logic               o_mpv,
  output logic               o_sie,
  output logic               o_spie,
  output logic               o_spp,
  output logic               o_spv
);
  logic [XLEN-1:0]    sel_pc;
  logic               take;
  logic               fault;
  logic [CAUSE_W-1:0] cause;
  stat_t              st_in, st_nx, st_q;
  logic [1:0]         priv_nx, priv_q;
  logic               virt_nx, virt_q, swap_nx;

  assign sel_pc = req_sret ? sepc : mepc;
  assign take   = req_valid && req_ready;
  assign st_in  = '{mie: st_mie, mpie: st_mpie, mpp: st_mpp, mpv: st_mpv,
                    sie: st_sie, spie: st_spie, spp: st_spp, spv: hs_spv};

  trp_legality u_legal (
    .is_sret   (req_sret),
    .priv      (cur_priv),
    .virt      (cur_virt),
    .ext_c     (ext_c),
    .ext_h     (ext_h),
    .pmp_on    (pmp_on),
    .pmp_empty (pmp_empty),
    .tsr       (st_tsr),
    .vtsr      (hs_vtsr),
    .mpp       (st_mpp),
    .pc_low    (sel_pc[1:0]),
    .fault     (fault),
    .cause     (cause)
  );

  trp_fields u_fields (
    .is_sret  (req_sret),
    .ext_h    (ext_h),
    .virt     (cur_virt),
    .st_in    (st_in),
    .st_out   (st_nx),
    .new_priv (priv_nx),
    .new_virt (virt_nx),
    .swap     (swap_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_ready   <= 1'b0;
      redir_valid <= 1'b0;
      redir_pc    <= '0;
      swap_req    <= 1'b0;
      exc_valid   <= 1'b0;
      exc_cause   <= '0;
      st_q        <= '0;
      priv_q      <= PRIV_M;
      virt_q      <= 1'b0;
    end else begin
      req_ready   <= 1'b1;
      redir_valid <= take && !fault;
      exc_valid   <= take && fault;
      swap_req    <= take && !fault && swap_nx;
      if (take && fault) exc_cause <= cause;
      if (take && !fault) begin
        redir_pc <= sel_pc;
        st_q     <= st_nx;
        priv_q   <= priv_nx;
        virt_q   <= virt_nx;
      end
    end
  end

  assign o_priv = priv_q;
  assign o_virt = virt_q;
  assign o_mie  = st_q.mie;
  assign o_mpie = st_q.mpie;
  assign o_mpp  = st_q.mpp;
  assign o_mpv  = st_q.mpv;
  assign o_sie  = st_q.sie;
  assign o_spie = st_q.spie;
  assign o_spp  = st_q.spp;
  assign o_spv  = st_q.spv;

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(redir_valid && exc_valid)); // R12
  AST_EXC_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> ($stable(st_q) && $stable(priv_q) && $stable(virt_q))); // R12
  AST_MRET_FROM_M: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && !$past(req_sret)) |-> ($past(cur_priv) == PRIV_M)); // R1
  AST_MRET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && !$past(req_sret)) |-> (o_mpp == PRIV_U && o_mpie && !o_mpv)); // R6
  AST_SRET_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && $past(req_sret)) |-> (o_spie && !o_spp && o_priv != PRIV_M)); // R9
  AST_MISALIGN_NEEDS_NO_C: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_cause == CAUSE_MISALIGN) |-> !$past(ext_c)); // R3
  AST_VIRT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_cause == CAUSE_VIRT) |-> $past(ext_h && cur_virt && req_sret)); // R5
endmodule

// File: tb/trap_return_unit_test.sv
module trap_return_unit_test;
  localparam int XLEN = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_sret = 1'b0;
  logic [1:0] cur_priv = 2'd3;
  logic cur_virt = 0, ext_c = 0, ext_h = 0, pmp_on = 0, pmp_empty = 0;
  logic st_mie = 0, st_mpie = 0, st_mpv = 0, st_sie = 0, st_spie = 0, st_spp = 0;
  logic [1:0] st_mpp = 2'd0;
  logic st_tsr = 0, hs_spv = 0, hs_vtsr = 0;
  logic [XLEN-1:0] mepc = '0, sepc = '0;
  logic redir_valid, swap_req, exc_valid;
  logic [XLEN-1:0] redir_pc;
  logic [4:0] exc_cause;
  logic [1:0] o_priv, o_mpp;
  logic o_virt, o_mie, o_mpie, o_mpv, o_sie, o_spie, o_spp, o_spv;

  int checks = 0, failures = 0;
  logic [11:0] exp_img;

  always #4 clk = ~clk;

  trap_return_unit #(.XLEN(XLEN)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_sret(req_sret), .cur_priv(cur_priv), .cur_virt(cur_virt), .ext_c(ext_c),
    .ext_h(ext_h), .pmp_on(pmp_on), .pmp_empty(pmp_empty), .st_mie(st_mie),
    .st_mpie(st_mpie), .st_mpp(st_mpp), .st_mpv(st_mpv), .st_sie(st_sie),
    .st_spie(st_spie), .st_spp(st_spp), .st_tsr(st_tsr), .hs_spv(hs_spv),
    .hs_vtsr(hs_vtsr), .mepc(mepc), .sepc(sepc), .redir_valid(redir_valid),
    .redir_pc(redir_pc), .swap_req(swap_req), .exc_valid(exc_valid),
    .exc_cause(exc_cause), .o_priv(o_priv), .o_virt(o_virt), .o_mie(o_mie),
    .o_mpie(o_mpie), .o_mpp(o_mpp), .o_mpv(o_mpv), .o_sie(o_sie), .o_spie(o_spie),
    .o_spp(o_spp), .o_spv(o_spv)
  );

  function automatic logic [11:0] got_img();
    return {o_priv, o_virt, o_mie, o_mpie, o_mpp, o_mpv, o_sie, o_spie, o_spp, o_spv};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] got,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  // Bench model built from the requirements
  task automatic model(output bit flt, output logic [4:0] cs,
                       output logic [11:0] img, output bit swp);
    logic [XLEN-1:0] pc;
    bit mis;
    logic [1:0] np;
    logic nv, mie, mpie, mpv, sie, spie, spp, spv;
    logic [1:0] mpp;
    pc  = req_sret ? sepc : mepc;
    mis = !ext_c && (pc[1:0] != 2'b00);
    flt = 0; cs = 5'd0; swp = 0;
    if (!req_sret) begin
      if (cur_priv != 2'd3) begin flt = 1; cs = 5'd2; end
      else if (mis) begin flt = 1; cs = 5'd0; end
      else if (pmp_on && pmp_empty && st_mpp != 2'd3) begin flt = 1; cs = 5'd2; end
    end else begin
      if (cur_priv == 2'd0) begin flt = 1; cs = 5'd2; end
      else if (mis) begin flt = 1; cs = 5'd0; end
      else if (st_tsr && cur_priv != 2'd3) begin flt = 1; cs = 5'd2; end
      else if (ext_h && cur_virt && hs_vtsr) begin flt = 1; cs = 5'd22; end
    end
    mie = st_mie; mpie = st_mpie; mpp = st_mpp; mpv = st_mpv;
    sie = st_sie; spie = st_spie; spp = st_spp; spv = hs_spv; nv = cur_virt;
    if (!req_sret) begin
      np = st_mpp; mie = st_mpie; mpie = 1; mpp = 2'd0; mpv = 0;
      if (ext_h) begin nv = st_mpv; swp = st_mpv; end
    end else begin
      np = {1'b0, st_spp}; sie = st_spie; spie = 1; spp = 0;
      if (ext_h && !cur_virt) begin spv = 0; nv = hs_spv; swp = hs_spv; end
    end
    img = {np, nv, mie, mpie, mpp, mpv, sie, spie, spp, spv};
  endtask

  task automatic run(input string tag);
    bit flt, swp;
    logic [4:0] cs;
    logic [11:0] img;
    logic [XLEN-1:0] pc;
    model(flt, cs, img, swp);
    pc = req_sret ? sepc : mepc;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(redir_valid == !flt && exc_valid == flt, {tag, " strobes"},
        {redir_valid, exc_valid}, {!flt, flt});
    if (flt) chk(exc_cause == cs, {tag, " cause"}, exc_cause, cs);
    else begin
      exp_img = img;
      chk(redir_pc == pc, {tag, " pc"}, redir_pc, pc);
      chk(swap_req == swp, {tag, " swap"}, swap_req, swp);
    end
    chk(got_img() == exp_img, {tag, " state"}, got_img(), exp_img);
    @(negedge clk);
    chk(!redir_valid && !exc_valid && !swap_req, {tag, " R12 pulse ends"},
        {redir_valid, exc_valid, swap_req}, 0);
  endtask

  task automatic clear_in();
    req_sret = 0; cur_priv = 2'd3; cur_virt = 0; ext_c = 0; ext_h = 0;
    pmp_on = 0; pmp_empty = 0; st_mie = 0; st_mpie = 0; st_mpp = 0; st_mpv = 0;
    st_sie = 0; st_spie = 0; st_spp = 0; st_tsr = 0; hs_spv = 0; hs_vtsr = 0;
    mepc = 32'h0000_1000; sepc = 32'h0000_2000;
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    exp_img = {2'd3, 10'd0};
    repeat (3) @(negedge clk);
    chk(got_img() == exp_img && !redir_valid && !exc_valid && !req_ready,
        "R13 reset state", {got_img(), req_ready}, {exp_img, 1'b0});
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R13 ready after reset", req_ready, 1);

    clear_in(); st_mpp = 2'd1; st_mpie = 1; ext_h = 1; st_sie = 1;
    run("R6 mret to S");
    clear_in(); ext_h = 1; st_mpv = 1; st_mpp = 2'd1;
    run("R7 mret restores virt");
    clear_in(); ext_h = 0; st_mpv = 1; cur_virt = 1;
    run("R7 mret without H");
    clear_in(); cur_priv = 2'd1;
    run("R1 mret from S");
    clear_in(); cur_priv = 2'd0; req_sret = 1;
    run("R2 sret from U");
    clear_in(); req_sret = 1; sepc = 32'h102;
    run("R3 misaligned no C");
    clear_in(); req_sret = 1; sepc = 32'h102; ext_c = 1; st_spp = 1;
    run("R3 half aligned with C");
    clear_in(); req_sret = 1; cur_priv = 2'd1; st_tsr = 1;
    run("R4 tsr at S");
    clear_in(); req_sret = 1; st_tsr = 1; st_spie = 1;
    run("R4 tsr at M");
    clear_in(); req_sret = 1; cur_priv = 2'd1; ext_h = 1; cur_virt = 1; hs_vtsr = 1;
    run("R5 vtsr");
    clear_in(); req_sret = 1; cur_priv = 2'd1; ext_h = 1; hs_spv = 1; st_spp = 1; st_spie = 1;
    run("R8 sret hyp path");
    clear_in(); req_sret = 1; cur_priv = 2'd1; ext_h = 1; cur_virt = 1; hs_spv = 1; st_spp = 1;
    run("R9 sret in virtual mode");
    clear_in(); req_sret = 1; st_spp = 1; hs_spv = 1;
    run("R9 sret no H");
    clear_in(); pmp_on = 1; pmp_empty = 1; st_mpp = 2'd0;
    run("R10 empty protection");
    clear_in(); pmp_on = 1; pmp_empty = 1; st_mpp = 2'd3; st_mpie = 1;
    run("R10 empty protection to M");
    clear_in(); req_sret = 1; cur_priv = 2'd0; sepc = 32'h3;
    run("R11 priv before align");
    clear_in(); mepc = 32'h1; pmp_on = 1; pmp_empty = 1;
    run("R11 align before protection");
    clear_in(); req_sret = 1; cur_priv = 2'd1; sepc = 32'h2; st_tsr = 1; ext_h = 1;
    cur_virt = 1; hs_vtsr = 1;
    run("R11 align before tsr");

    for (int i = 0; i < 400; i++) begin
      logic [1:0] p;
      p = 2'($urandom_range(0, 2));
      cur_priv  = (p == 2'd2) ? 2'd3 : p;
      req_sret  = 1'($urandom);
      cur_virt  = 1'($urandom); ext_c = 1'($urandom); ext_h = 1'($urandom);
      pmp_on    = 1'($urandom); pmp_empty = 1'($urandom);
      st_mie    = 1'($urandom); st_mpie = 1'($urandom); st_mpp = 2'($urandom);
      st_mpv    = 1'($urandom); st_sie = 1'($urandom); st_spie = 1'($urandom);
      st_spp    = 1'($urandom); st_tsr = ($urandom_range(0, 3) == 0);
      hs_spv    = 1'($urandom); hs_vtsr = ($urandom_range(0, 3) == 0);
      mepc      = $urandom; sepc = $urandom;
      if ($urandom_range(0, 9) < 7) begin mepc[1:0] = 2'b00; sepc[1:0] = 2'b00; end
      run("R11 R12 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule